// File: doc/BRIEF.md
# Virtual Scan-Node Hub

This block lets several virtual scan nodes share one physical test access port that offers only two user instructions. While the first user instruction (the "virtual-IR" select) is active, data-register scans pass through a virtual instruction register. That register holds a node address in its upper bits and an instruction value for the addressed node in its lower bits. While the second user instruction (the "virtual-DR" select) is active, data scans go to one of two places. If the address held is a node, they go to that node's data path. If the address and the instruction are both zero, they go to the hub's own discovery stream.

Host software learns the size of the virtual IR and the identity of each node from the discovery stream. It reads that stream as a run of 4-bit scans. Each scan yields one nibble, and the stream moves to the next nibble only when a scan finishes with Update-DR. The first 32-bit word describes the hub. One 32-bit word per node follows, in address order. The block runs on the TAP clock and takes the capture, shift and update strobes as single-cycle enables.

Top module: `vjtag_hub`

## Requirements
- R1: The virtual IR is A+M bits wide, where A = ceil(log2(NODES+1)) is the address width and M is the instruction width. The address is in bits [A+M-1:M] and the instruction in bits [M-1:0]. While the virtual-IR select and shift are high, the register shifts toward bit 0, takes tdi into its top bit, and drives bit 0 on tdo. Capture loads the value last written.
- R2: An update of the virtual IR with an address k from 1 to NODES copies the instruction field into node k's instruction output. The same edge raises node k's update strobe, and no other strobe, for exactly one cycle. An update with address 0 changes no node output and raises no strobe.
- R3: When the virtual-DR select is high and the virtual IR holds address 0 and instruction 0, each capture loads one 4-bit nibble of the discovery stream. Four shifts then present that nibble on tdo, least significant bit first.
- R4: The discovery pointer advances by one nibble only on an Update-DR of a discovery scan. A scan that ends without an update returns the same nibble again.
- R5: The first eight nibbles, least significant nibble first, form the hub word: version in [31:27], NODES in [26:19], the manufacturer code 0x06E in [18:8] and M in [7:0].
- R6: The hub word is followed by one 32-bit word per node, in order of address 1 to NODES, each read out least significant nibble first. The words come from the NODE_INFO parameter, with node k taken from bits [32k-1:32k-32].
- R7: Once all node words have been read, every further discovery nibble is 0.
- R8: Any update of the virtual IR returns the discovery pointer to the first nibble of the hub word.
- R9: While test-logic-reset (tlr) is high, the virtual IR is cleared to address 0 and instruction 0, and the discovery pointer returns to the start. If tlr is high in the same cycle as a virtual-IR update, tlr takes priority: no node output changes and no strobe fires.
- R10: When the virtual IR holds a node address k, the virtual-DR select raises only node k's data-select output, and tdo follows node k's node_tdo input. When neither the discovery stream nor a node is selected, tdo is 0.
- R11: A synchronous active-low rst_n clears the virtual IR, the discovery pointer, every node instruction output and every strobe, and drives tdo to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | TAP clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tlr | input | 1 | TAP is in Test-Logic-Reset |
| tdi | input | 1 | Serial scan input |
| capture_dr | input | 1 | Capture-DR strobe |
| shift_dr | input | 1 | Shift-DR strobe |
| update_dr | input | 1 | Update-DR strobe |
| sel_vir | input | 1 | First user instruction active (virtual IR path) |
| sel_vdr | input | 1 | Second user instruction active (virtual DR path) |
| node_tdo | input | NODES | Serial output of each node's data path |
| tdo | output | 1 | Serial scan output |
| node_ir | output | NODES*M_W | Latched instruction of each node, node k in slice k-1 |
| node_ir_upd | output | NODES | One-cycle strobe per node on a new instruction |
| node_dr_sel | output | NODES | Data path select per node |

## Verification
Two functions can act in the same cycle: a virtual-IR update aimed at a node, and a test-logic-reset. The bench raises tlr during the update cycle of a scan addressed to node 1. It then checks three things: node 1's strobe stays low, node 1's instruction keeps its old value, and the next virtual-IR readback returns zero. A second pairing puts a discovery update next to a fresh virtual-IR write. The bench checks that the write wins and that the stream restarts at the hub word.

// File: rtl/vjtag_pkg.sv
// Package: shared constants and the word builder for the discovery stream.
// Assumes a 32-bit discovery word made of version, id, manufacturer and instance fields.
package vjtag_pkg;

    localparam logic [10:0] HUB_MFG_CODE = 11'h06E;
    localparam int          WORD_W       = 32;
    localparam int          NIB_PER_WORD = 8;

    // Pack the four fields of one discovery word.
    function automatic logic [31:0] pack_info(
        input logic [4:0]  ver,
        input logic [7:0]  id,
        input logic [10:0] mfg,
        input logic [7:0]  inst
    );
        return {ver, id, mfg, inst};
    endfunction

endpackage

// File: rtl/vjtag_vir.sv
// Module: virtual instruction register and the per-node instruction latches.
// Holds a shift stage and a parallel register, each {address, instruction}.
// On a virtual-IR update it loads the node register at the address held and
// raises that node's strobe for one cycle. Assumes the strobes are one-cycle
// enables on tck and that tlr outranks any update.
module vjtag_vir #(
    parameter int NODES = 3,
    parameter int M_W   = 4,
    parameter int A_W   = 2
) (
    input  logic                   tck,
    input  logic                   rst_n,
    input  logic                   tlr,
    input  logic                   tdi,
    input  logic                   capture_dr,
    input  logic                   shift_dr,
    input  logic                   update_dr,
    input  logic                   sel_vir,
    output logic [A_W-1:0]         vir_addr,
    output logic [M_W-1:0]         vir_inst,
    output logic                   vir_tdo,
    output logic                   vir_write,
    output logic [NODES*M_W-1:0]   node_ir,
    output logic [NODES-1:0]       node_ir_upd
);

    localparam int VW = A_W + M_W;

    logic [VW-1:0] shf_q;
    logic [VW-1:0] vir_q;

    // A virtual-IR write that is not overruled by tlr
    assign vir_write = sel_vir && update_dr && !tlr;

    // Shift stage and parallel register of the virtual IR
    always_ff @(posedge tck) begin
        if (!rst_n) begin
            shf_q <= '0;
            vir_q <= '0;
        end else if (tlr) begin
            shf_q <= '0;
            vir_q <= '0;
        end else if (sel_vir) begin
            if (capture_dr)
                shf_q <= vir_q;
            else if (shift_dr)
                shf_q <= {tdi, shf_q[VW-1:1]};
            if (update_dr)
                vir_q <= shf_q;
        end
    end

    assign vir_addr = vir_q[VW-1:M_W];
    assign vir_inst = vir_q[M_W-1:0];
    assign vir_tdo  = shf_q[0];

    genvar k;
    generate
        for (k = 0; k < NODES; k++) begin : g_node
            logic [M_W-1:0] ir_q;
            logic           upd_q;

            // Latch this node's instruction and raise its strobe on a write addressed to it
            always_ff @(posedge tck) begin
                if (!rst_n) begin
                    ir_q  <= '0;
                    upd_q <= 1'b0;
                end else begin
                    upd_q <= 1'b0;
                    if (vir_write && shf_q[VW-1:M_W] == A_W'(k + 1)) begin
                        ir_q  <= shf_q[M_W-1:0];
                        upd_q <= 1'b1;
                    end
                end
            end

            assign node_ir[k*M_W +: M_W] = ir_q;
            assign node_ir_upd[k]        = upd_q;
        end
    endgenerate

    AST_UPD_ONEHOT: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(node_ir_upd)); // R2

    AST_UPD_CAUSE: assert property (@(posedge tck) disable iff (!rst_n)
        (|node_ir_upd) |-> $past(sel_vir && update_dr && !tlr)); // R2

    AST_TLR_CLEARS_VIR: assert property (@(posedge tck) disable iff (!rst_n)
        tlr |=> (vir_addr == '0 && vir_inst == '0)); // R9

    AST_TLR_NO_STROBE: assert property (@(posedge tck) disable iff (!rst_n)
        tlr |=> (node_ir_upd == '0)); // R9

endmodule

// File: rtl/vjtag_info.sv
// Module: discovery stream. It serves the hub word and then one word per node
// as 4-bit scans. A nibble pointer moves one step on each Update-DR of a
// discovery scan and stops past the last word, where the stream reads zero.
// Assumes the top gates 'sel' so that it is high only while discovery is addressed.
module vjtag_info
    import vjtag_pkg::*;
#(
    parameter int                  NODES     = 3,
    parameter int                  M_W       = 4,
    parameter logic [4:0]          HUB_VER   = 5'd1,
    parameter logic [NODES*32-1:0] NODE_INFO = '0
) (
    input  logic tck,
    input  logic rst_n,
    input  logic tlr,
    input  logic vir_write,
    input  logic sel,
    input  logic tdi,
    input  logic capture_dr,
    input  logic shift_dr,
    input  logic update_dr,
    output logic info_tdo
);

    localparam int TOTAL = (NODES + 1) * NIB_PER_WORD;
    localparam int P_W   = $clog2(TOTAL + 1);
    localparam int IX_W  = P_W - 3;

    logic [WORD_W-1:0] words [NODES+1];
    logic [P_W-1:0]    ptr_q;
    logic [WORD_W-1:0] cur_word;
    logic [3:0]        cur_nib;
    logic [3:0]        nsr_q;

    assign words[0] = pack_info(HUB_VER, 8'(NODES), HUB_MFG_CODE, 8'(M_W));

    genvar w;
    generate
        for (w = 0; w < NODES; w++) begin : g_word
            assign words[w+1] = NODE_INFO[w*32 +: 32];
        end
    endgenerate

    // Pick the word under the pointer; zero once the pointer is past the end
    always_comb begin
        cur_word = '0;
        for (int i = 0; i <= NODES; i++) begin
            if (ptr_q[P_W-1:3] == IX_W'(i))
                cur_word = words[i];
        end
        cur_nib = cur_word[{ptr_q[2:0], 2'b00} +: 4];
    end

    // Nibble pointer: clear on tlr or a virtual-IR write, step on a discovery update
    always_ff @(posedge tck) begin
        if (!rst_n)
            ptr_q <= '0;
        else if (tlr || vir_write)
            ptr_q <= '0;
        else if (sel && update_dr && ptr_q < P_W'(TOTAL))
            ptr_q <= ptr_q + P_W'(1);
    end

    // 4-bit shift stage that carries the nibble out
    always_ff @(posedge tck) begin
        if (!rst_n)
            nsr_q <= '0;
        else if (tlr)
            nsr_q <= '0;
        else if (sel) begin
            if (capture_dr)
                nsr_q <= cur_nib;
            else if (shift_dr)
                nsr_q <= {tdi, nsr_q[3:1]};
        end
    end

    assign info_tdo = nsr_q[0];

    AST_PTR_BOUND: assert property (@(posedge tck) disable iff (!rst_n)
        ptr_q <= P_W'(TOTAL)); // R7

    AST_PTR_STEP: assert property (@(posedge tck) disable iff (!rst_n)
        (ptr_q != $past(ptr_q)) |-> (ptr_q == '0 || ptr_q == $past(ptr_q) + P_W'(1))); // R4

    AST_PTR_RESTART: assert property (@(posedge tck) disable iff (!rst_n)
        (tlr || vir_write) |=> (ptr_q == '0)); // R8

endmodule

// File: rtl/vjtag_hub.sv
// Module: top of the virtual scan-node hub. Connects the virtual IR and the
// discovery stream, decodes the node data selects and picks the source of tdo.
// Assumes the physical TAP supplies the strobes and the two instruction selects
// on tck, and that at most one of sel_vir and sel_vdr is high at a time.
module vjtag_hub
    import vjtag_pkg::*;
#(
    parameter int                  NODES     = 3,
    parameter int                  M_W       = 4,
    parameter logic [4:0]          HUB_VER   = 5'd1,
    parameter logic [NODES*32-1:0] NODE_INFO = {
        pack_info(5'd1, 8'h08, HUB_MFG_CODE, 8'd1),
        pack_info(5'd1, 8'h84, HUB_MFG_CODE, 8'd0),
        pack_info(5'd1, 8'h08, HUB_MFG_CODE, 8'd0)
    }
) (
    input  logic                 tck,
    input  logic                 rst_n,
    input  logic                 tlr,
    input  logic                 tdi,
    input  logic                 capture_dr,
    input  logic                 shift_dr,
    input  logic                 update_dr,
    input  logic                 sel_vir,
    input  logic                 sel_vdr,
    input  logic [NODES-1:0]     node_tdo,
    output logic                 tdo,
    output logic [NODES*M_W-1:0] node_ir,
    output logic [NODES-1:0]     node_ir_upd,
    output logic [NODES-1:0]     node_dr_sel
);

    localparam int A_W = $clog2(NODES + 1);

    logic [A_W-1:0] vir_addr;
    logic [M_W-1:0] vir_inst;
    logic           vir_tdo;
    logic           vir_write;
    logic           info_sel;
    logic           info_tdo;

    vjtag_vir #(.NODES(NODES), .M_W(M_W), .A_W(A_W)) u_vir (
        .tck         (tck),
        .rst_n       (rst_n),
        .tlr         (tlr),
        .tdi         (tdi),
        .capture_dr  (capture_dr),
        .shift_dr    (shift_dr),
        .update_dr   (update_dr),
        .sel_vir     (sel_vir),
        .vir_addr    (vir_addr),
        .vir_inst    (vir_inst),
        .vir_tdo     (vir_tdo),
        .vir_write   (vir_write),
        .node_ir     (node_ir),
        .node_ir_upd (node_ir_upd)
    );

    // Discovery is addressed by hub address 0 with instruction 0
    assign info_sel = sel_vdr && vir_addr == '0 && vir_inst == '0;

    vjtag_info #(.NODES(NODES), .M_W(M_W), .HUB_VER(HUB_VER), .NODE_INFO(NODE_INFO)) u_info (
        .tck        (tck),
        .rst_n      (rst_n),
        .tlr        (tlr),
        .vir_write  (vir_write),
        .sel        (info_sel),
        .tdi        (tdi),
        .capture_dr (capture_dr),
        .shift_dr   (shift_dr),
        .update_dr  (update_dr),
        .info_tdo   (info_tdo)
    );

    genvar k;
    generate
        for (k = 0; k < NODES; k++) begin : g_sel
            assign node_dr_sel[k] = sel_vdr && vir_addr == A_W'(k + 1);
        end
    endgenerate

    // Source of tdo: virtual IR, discovery stream, selected node, or 0
    always_comb begin
        if (sel_vir)
            tdo = vir_tdo;
        else if (info_sel)
            tdo = info_tdo;
        else
            tdo = |(node_tdo & node_dr_sel);
    end

    AST_DRSEL_ONEHOT: assert property (@(posedge tck) disable iff (!rst_n)
        $onehot0(node_dr_sel)); // R10

    AST_DRSEL_NEEDS_VDR: assert property (@(posedge tck) disable iff (!rst_n)
        (|node_dr_sel) |-> (sel_vdr && !info_sel)); // R10

endmodule

// File: tb/vjtag_hub_tb.sv
module vjtag_hub_tb_top;
    import vjtag_pkg::*;

    localparam int NODES = 3;
    localparam int M_W   = 4;
    localparam logic [31:0] W_HUB = {5'd1, 8'd3, 11'h06E, 8'd4};
    localparam logic [31:0] W_N1  = {5'd1, 8'h08, 11'h06E, 8'd0};
    localparam logic [31:0] W_N2  = {5'd1, 8'h84, 11'h06E, 8'd0};
    localparam logic [31:0] W_N3  = {5'd1, 8'h08, 11'h06E, 8'd1};

    logic tck = 1'b0;
    logic rst_n = 1'b0;
    logic tlr = 1'b0, tdi = 1'b0, capture_dr = 1'b0, shift_dr = 1'b0, update_dr = 1'b0;
    logic sel_vir = 1'b0, sel_vdr = 1'b0;
    logic [NODES-1:0] node_tdo = '0;
    logic tdo;
    logic [NODES*M_W-1:0] node_ir;
    logic [NODES-1:0] node_ir_upd, node_dr_sel;

    int total = 0;
    int bad = 0;

    logic [3:0] exp_q [$];
    string      tag_q [$];
    logic [3:0] got_nib;
    event       nib_ev;

    vjtag_hub #(.NODES(NODES), .M_W(M_W), .HUB_VER(5'd1),
                .NODE_INFO({W_N3, W_N2, W_N1})) dut_i (
        .tck(tck), .rst_n(rst_n), .tlr(tlr), .tdi(tdi),
        .capture_dr(capture_dr), .shift_dr(shift_dr), .update_dr(update_dr),
        .sel_vir(sel_vir), .sel_vdr(sel_vdr), .node_tdo(node_tdo),
        .tdo(tdo), .node_ir(node_ir), .node_ir_upd(node_ir_upd), .node_dr_sel(node_dr_sel)
    );

    always #4 tck = ~tck;

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Monitor: pop the next expected nibble and compare it with the scanned one
    always @(nib_ev) begin
        logic [3:0] e;
        string t;
        if (exp_q.size() == 0) begin
            chk(1'b0, "R3 (no expected item)", {28'd0, got_nib}, 32'd0);
        end else begin
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(got_nib == e, t, {28'd0, got_nib}, {28'd0, e});
        end
    end

    task automatic push_word(input logic [31:0] w, input string t);
        for (int i = 0; i < 8; i++) begin
            exp_q.push_back(w[i*4 +: 4]);
            tag_q.push_back(t);
        end
    endtask

    task automatic push_nib(input logic [3:0] n, input string t);
        exp_q.push_back(n);
        tag_q.push_back(t);
    endtask

    // One virtual-IR scan; returns the value captured; optional tlr in the update cycle
    task automatic vir_scan(input logic [1:0] a, input logic [3:0] i, input bit tlr_upd,
                            output logic [5:0] old);
        logic [5:0] v;
        v = {a, i};
        sel_vir = 1'b1; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        for (int b = 0; b < 6; b++) begin
            shift_dr = 1'b1; tdi = v[b];
            #1 old[b] = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = 1'b1; tlr = tlr_upd;
        @(negedge tck);
        update_dr = 1'b0; tlr = 1'b0; sel_vir = 1'b0;
    endtask

    // Driver: one 4-bit scan under the virtual-DR select, posted to the monitor
    task automatic nib_scan(input bit do_upd);
        logic [3:0] n;
        sel_vdr = 1'b1; capture_dr = 1'b1;
        @(negedge tck);
        capture_dr = 1'b0;
        for (int b = 0; b < 4; b++) begin
            shift_dr = 1'b1; tdi = 1'b0;
            #1 n[b] = tdo;
            @(negedge tck);
        end
        shift_dr = 1'b0; update_dr = do_upd;
        @(negedge tck);
        update_dr = 1'b0; sel_vdr = 1'b0;
        got_nib = n;
        -> nib_ev;
        #1;
    endtask

    initial begin
        repeat (200000) @(posedge tck);
        chk(1'b0, "watchdog", 32'd0, 32'd1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [5:0] old;
        repeat (3) @(negedge tck);
        // R11: reset state
        chk(tdo == 1'b0, "R11 tdo", {31'd0, tdo}, 32'd0);
        chk(node_ir == '0 && node_ir_upd == '0, "R11 node outputs", {20'd0, node_ir}, 32'd0);
        rst_n = 1'b1;
        @(negedge tck);

        // R3 R5: hub word; R6: node words; R7: zeros past end
        push_word(W_HUB, "R5 hub word");
        push_word(W_N1, "R6 node1 word");
        push_word(W_N2, "R6 node2 word");
        push_word(W_N3, "R6 node3 word");
        for (int i = 0; i < 4; i++) push_nib(4'h0, "R7 past end");
        for (int i = 0; i < 36; i++) nib_scan(1'b1);

        // R8: virtual-IR write restarts the stream
        vir_scan(2'd0, 4'd0, 1'b0, old);
        push_nib(W_HUB[3:0], "R8 restart nibble0");
        nib_scan(1'b1);
        // R4: no update -> same nibble repeats
        push_nib(W_HUB[7:4], "R4 nibble1");
        nib_scan(1'b0);
        push_nib(W_HUB[7:4], "R4 nibble1 repeated");
        nib_scan(1'b1);
        push_nib(W_HUB[11:8], "R4 nibble2 after update");
        nib_scan(1'b1);

        // R2: write node 2 instruction 0xA
        vir_scan(2'd2, 4'hA, 1'b0, old);
        chk(node_ir_upd == 3'b010, "R2 strobe", {29'd0, node_ir_upd}, 32'd2);
        chk(node_ir[7:4] == 4'hA, "R2 node2 instruction", {28'd0, node_ir[7:4]}, 32'hA);
        chk(node_ir[3:0] == 4'h0 && node_ir[11:8] == 4'h0, "R2 other nodes", {20'd0, node_ir}, 32'h0A0);
        @(negedge tck);
        chk(node_ir_upd == 3'b000, "R2 strobe one cycle", {29'd0, node_ir_upd}, 32'd0);

        // R10: node 2 data path
        sel_vdr = 1'b1; node_tdo = 3'b010;
        #1 chk(node_dr_sel == 3'b010, "R10 select", {29'd0, node_dr_sel}, 32'd2);
        chk(tdo == 1'b1, "R10 tdo follows node2", {31'd0, tdo}, 32'd1);
        node_tdo = 3'b101;
        #1 chk(tdo == 1'b0, "R10 tdo ignores others", {31'd0, tdo}, 32'd0);
        sel_vdr = 1'b0; node_tdo = '0;
        @(negedge tck);

        // R1: readback of the previous value, bit layout {addr, inst}
        vir_scan(2'd0, 4'h5, 1'b0, old);
        chk(old == 6'b10_1010, "R1 readback", {26'd0, old}, 32'h2A);
        chk(node_ir_upd == 3'b000 && node_ir[7:4] == 4'hA, "R2 address 0 no effect",
            {20'd0, node_ir}, 32'h0A0);
        sel_vdr = 1'b1;
        #1 chk(tdo == 1'b0 && node_dr_sel == '0, "R10 nothing selected", {31'd0, tdo}, 32'd0);
        sel_vdr = 1'b0;
        @(negedge tck);

        // R9: tlr in the same cycle as an update aimed at node 1
        vir_scan(2'd1, 4'h3, 1'b1, old);
        chk(old == 6'b00_0101, "R1 readback addr0", {26'd0, old}, 32'h05);
        chk(node_ir_upd == 3'b000, "R9 no strobe under tlr", {29'd0, node_ir_upd}, 32'd0);
        chk(node_ir[3:0] == 4'h0, "R9 node1 unchanged", {28'd0, node_ir[3:0]}, 32'd0);
        vir_scan(2'd0, 4'd0, 1'b0, old);
        chk(old == 6'd0, "R9 virtual IR cleared", {26'd0, old}, 32'd0);

        // R9: tlr resets the discovery pointer
        push_nib(W_HUB[3:0], "R9 pre nibble0");
        nib_scan(1'b1);
        push_nib(W_HUB[7:4], "R9 pre nibble1");
        nib_scan(1'b1);
        tlr = 1'b1;
        @(negedge tck);
        tlr = 1'b0;
        push_nib(W_HUB[3:0], "R9 pointer restart");
        nib_scan(1'b1);

        // R11: reset in mid-operation clears node outputs
        rst_n = 1'b0;
        @(negedge tck);
        chk(node_ir == '0, "R11 node outputs cleared", {20'd0, node_ir}, 32'd0);
        rst_n = 1'b1;
        @(negedge tck);

        chk(exp_q.size() == 0, "R3 all expected consumed", exp_q.size(), 32'd0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule